// File: doc/BRIEF.md
# Byte-Wide Cache Block Refill Engine

This engine loads one cache block of four 32-bit words over a memory bus that is eight bits wide and clocked at half the CPU rate. The cache controller raises a one-clock start request together with the block address when a miss has occurred. The engine then walks the sixteen byte addresses of the block in ascending order and reads one byte every second CPU clock. It packs each group of four bytes into a word and hands every finished word to the block buffer with a write strobe and a word index.

All timing is kept in CPU clocks. A fixed lead-in of four clocks covers the trip to memory. The first byte is taken two clocks later, and each later byte follows two clocks after the one before it. The refill therefore finishes 36 clocks after the start, which equals the lead-in plus two clocks for each of the sixteen bytes. A cycle counter output shows how far the refill has progressed, and a bus-phase output marks the alternate clocks on which bus transfers can occur.

Top module: `refill_engine`

## Requirements
- R1: While reset is high and after it is released, busy_o, done_o, wr_en_o and mem_rd_o are 0, and cyc_cnt_o is 0.
- R2: A start_i sampled high while idle begins a refill. From the next clock busy_o is 1, cyc_cnt_o reads 0, and cyc_cnt_o then rises by one each clock.
- R3: The first byte read (mem_rd_o high, with the byte sampled at the end of that clock) happens while cyc_cnt_o is 5, so the first byte arrives 6 clocks after the start was sampled.
- R4: Bytes are read exactly 16 times per refill, with mem_rd_o high while cyc_cnt_o is 5, 7, 9 and so on up to 35, and never on two adjacent clocks.
- R5: During read k (k from 0 to 15), mem_addr_o equals the block address with its low 4 bits cleared, plus k.
- R6: Byte k is placed in bits [8*(k mod 4)+7 : 8*(k mod 4)] of word k/4 (little-endian). Word w is written with wr_en_o high for one clock, wr_idx_o equal to w and wr_data_o holding the packed word, on the clock after its fourth byte arrives (cyc_cnt_o equal to 12, 20, 28 or 36).
- R7: done_o is high for exactly one clock, while cyc_cnt_o is 36. On the next clock busy_o is 0 and the engine accepts a new start.
- R8: A start_i that arrives while busy_o is 1, including the clock on which done_o is high, has no effect on the counter, the addresses, the data or the completion time.
- R9: bus_phase_o is 1 while busy_o is 1 and cyc_cnt_o is odd, and 0 at all other times.
- R10: While no refill is running, mem_rd_o and wr_en_o stay 0, so memory is never read without a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-clock refill request from the cache controller |
| blk_addr_i | input | 32 | Byte address inside the block that missed |
| busy_o | output | 1 | Refill in progress |
| done_o | output | 1 | One-clock pulse when the block is complete |
| cyc_cnt_o | output | 6 | CPU clocks elapsed since the start was sampled |
| bus_phase_o | output | 1 | Marks the alternate clocks on which a bus transfer can occur |
| mem_rd_o | output | 1 | A byte is read this clock |
| mem_addr_o | output | 32 | Byte address of the current read |
| mem_byte_i | input | 8 | Read data from memory, sampled at the end of a read clock |
| wr_en_o | output | 1 | Word write strobe to the block buffer |
| wr_idx_o | output | 2 | Word index within the block |
| wr_data_o | output | 32 | Packed 32-bit word |

## Verification
The bench places extra start requests at random points of a refill, including the final clock on which done is raised. A design that accepted one of these would restart its counter or re-fetch bytes, and would miss the expected read positions. Block addresses are drawn at random, with the low address bits set and values near the top of the address space, so that an engine that skipped alignment would read from the wrong addresses. Each read byte comes from an address hash, so a word packed in the wrong lane order or written one clock early or late shows up as a data or strobe mismatch. Every clock of each refill is compared against the expected first-byte position at count 5 and the 36-clock completion, which catches an off-by-one in the lead-in or in the byte spacing.

// File: rtl/refill_pkg.sv
`timescale 1ns/1ps
package refill_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } refill_state_e;

    // Clock count from start sampling to the last byte landing.
    function automatic int refill_clks(input int lead, input int div, input int nbytes);
        return lead + div * nbytes;
    endfunction

    // Counter value during which the first byte read is issued.
    function automatic int first_read_cnt(input int lead, input int div);
        return lead + div - 1;
    endfunction

endpackage

// File: rtl/refill_timer.sv
`timescale 1ns/1ps
module refill_timer
    import refill_pkg::*;
#(
    parameter int LEAD_CLKS = 4,
    parameter int BUS_DIV   = 2,
    parameter int NBYTES    = 16,
    parameter int CNT_W     = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    output logic             busy_o,
    output logic             accept_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             phase_o,
    output logic             strobe_o,
    output logic             done_o
);
    localparam int TOTAL = refill_clks(LEAD_CLKS, BUS_DIV, NBYTES);
    localparam int FIRST = first_read_cnt(LEAD_CLKS, BUS_DIV);
    localparam logic [CNT_W-1:0] TOTAL_C = CNT_W'(TOTAL);
    localparam logic [CNT_W-1:0] FIRST_C = CNT_W'(FIRST);
    localparam logic [CNT_W-1:0] LAST_C  = CNT_W'(TOTAL - 1);
    localparam int PHASE_RES = FIRST % BUS_DIV;

    refill_state_e    state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             window;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_RUN;
                        cnt_q   <= '0;
                    end
                end
                default: begin
                    if (cnt_q == TOTAL_C) begin
                        state_q <= ST_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    always_comb begin
        busy_o   = (state_q == ST_RUN);
        accept_o = (state_q == ST_IDLE) && start_i;
        done_o   = busy_o && (cnt_q == TOTAL_C);
        phase_o  = busy_o && ((int'(cnt_q) % BUS_DIV) == PHASE_RES);
        window   = (cnt_q >= FIRST_C) && (cnt_q <= LAST_C);
        strobe_o = phase_o && window;
        cnt_o    = cnt_q;
    end

endmodule

// File: rtl/refill_assembler.sv
`timescale 1ns/1ps
module refill_assembler
    import refill_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NBYTES = 16,
    parameter int BPW    = 4,
    parameter int BI_W   = 4,
    parameter int LANE_W = 2,
    parameter int WI_W   = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load_i,
    input  logic [ADDR_W-1:0]     blk_addr_i,
    input  logic                  strobe_i,
    input  logic [BYTE_W-1:0]     mem_byte_i,
    output logic [ADDR_W-1:0]     mem_addr_o,
    output logic                  wr_en_o,
    output logic [WI_W-1:0]       wr_idx_o,
    output logic [BPW*BYTE_W-1:0] wr_data_o
);
    localparam int WORD_W = BPW * BYTE_W;
    localparam logic [LANE_W-1:0] TOP_LANE = LANE_W'(BPW - 1);

    logic [ADDR_W-1:0] base_q;
    logic [BI_W-1:0]   byte_idx_q;
    logic [WORD_W-1:0] word_q;
    logic [LANE_W-1:0] lane;
    logic              word_last;

    assign lane       = byte_idx_q[LANE_W-1:0];
    assign word_last  = strobe_i && (lane == TOP_LANE);
    assign mem_addr_o = base_q + ADDR_W'(byte_idx_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q     <= '0;
            byte_idx_q <= '0;
        end else if (load_i) begin
            base_q     <= {blk_addr_i[ADDR_W-1:BI_W], {BI_W{1'b0}}};
            byte_idx_q <= '0;
        end else if (strobe_i) begin
            byte_idx_q <= byte_idx_q + 1'b1;
        end
    end

    // One byte lane register per lane position.
    for (genvar g = 0; g < BPW; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                word_q[g*BYTE_W +: BYTE_W] <= '0;
            end else if (strobe_i && (lane == LANE_W'(g))) begin
                word_q[g*BYTE_W +: BYTE_W] <= mem_byte_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en_o   <= 1'b0;
            wr_idx_o  <= '0;
            wr_data_o <= '0;
        end else begin
            wr_en_o <= word_last;
            if (word_last) begin
                wr_idx_o  <= byte_idx_q[BI_W-1:LANE_W];
                wr_data_o <= {mem_byte_i, word_q[WORD_W-BYTE_W-1:0]};
            end
        end
    end

endmodule

// File: rtl/refill_engine.sv
`timescale 1ns/1ps
module refill_engine
    import refill_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int WORDS     = 4,
    parameter int BPW       = 4,
    parameter int LEAD_CLKS = 4,
    parameter int BUS_DIV   = 2,
    parameter int CNT_W     = $clog2(LEAD_CLKS + BUS_DIV * WORDS * BPW + 1),
    parameter int WI_W      = $clog2(WORDS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_i,
    input  logic [ADDR_W-1:0]     blk_addr_i,
    output logic                  busy_o,
    output logic                  done_o,
    output logic [CNT_W-1:0]      cyc_cnt_o,
    output logic                  bus_phase_o,
    output logic                  mem_rd_o,
    output logic [ADDR_W-1:0]     mem_addr_o,
    input  logic [7:0]            mem_byte_i,
    output logic                  wr_en_o,
    output logic [WI_W-1:0]       wr_idx_o,
    output logic [BPW*8-1:0]      wr_data_o
);
    localparam int NBYTES = WORDS * BPW;
    localparam int BI_W   = $clog2(NBYTES);
    localparam int LANE_W = $clog2(BPW);

    logic accept;
    logic strobe;

    refill_timer #(
        .LEAD_CLKS (LEAD_CLKS),
        .BUS_DIV   (BUS_DIV),
        .NBYTES    (NBYTES),
        .CNT_W     (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .busy_o   (busy_o),
        .accept_o (accept),
        .cnt_o    (cyc_cnt_o),
        .phase_o  (bus_phase_o),
        .strobe_o (strobe),
        .done_o   (done_o)
    );

    refill_assembler #(
        .ADDR_W (ADDR_W),
        .NBYTES (NBYTES),
        .BPW    (BPW),
        .BI_W   (BI_W),
        .LANE_W (LANE_W),
        .WI_W   (WI_W)
    ) u_asm (
        .clk        (clk),
        .rst        (rst),
        .load_i     (accept),
        .blk_addr_i (blk_addr_i),
        .strobe_i   (strobe),
        .mem_byte_i (mem_byte_i),
        .mem_addr_o (mem_addr_o),
        .wr_en_o    (wr_en_o),
        .wr_idx_o   (wr_idx_o),
        .wr_data_o  (wr_data_o)
    );

    assign mem_rd_o = strobe;

endmodule

// File: rtl/refill_engine_chk.sv
`timescale 1ns/1ps
module refill_engine_chk #(
    parameter int CNT_W = 6,
    parameter int TOTAL = 36,
    parameter int FIRST = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic             busy_o,
    input logic             done_o,
    input logic [CNT_W-1:0] cyc_cnt_o,
    input logic             mem_rd_o,
    input logic             wr_en_o
);
    assert_done_at_total_R7: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (cyc_cnt_o == CNT_W'(TOTAL)));

    assert_done_releases_R7: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !busy_o);

    assert_read_spacing_R4: assert property (@(posedge clk) disable iff (rst)
        mem_rd_o |=> !mem_rd_o);

    assert_no_idle_read_R10: assert property (@(posedge clk) disable iff (rst)
        mem_rd_o |-> busy_o);

    assert_first_read_R3: assert property (@(posedge clk) disable iff (rst)
        mem_rd_o |-> (cyc_cnt_o >= CNT_W'(FIRST)));

    assert_write_after_read_R6: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> $past(mem_rd_o));

    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !done_o && start_i) |=>
            (busy_o && (cyc_cnt_o == CNT_W'($past(cyc_cnt_o) + 1'b1))));

endmodule

bind refill_engine refill_engine_chk #(
    .CNT_W (CNT_W),
    .TOTAL (LEAD_CLKS + BUS_DIV * WORDS * BPW),
    .FIRST (LEAD_CLKS + BUS_DIV - 1)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .cyc_cnt_o (cyc_cnt_o),
    .mem_rd_o  (mem_rd_o),
    .wr_en_o   (wr_en_o)
);

// File: tb/tb_refill_engine.sv
`timescale 1ns/1ps
module tb_refill_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [31:0] blk_addr_i = '0;
    logic        busy_o, done_o, bus_phase_o, mem_rd_o, wr_en_o;
    logic [5:0]  cyc_cnt_o;
    logic [31:0] mem_addr_o, wr_data_o;
    logic [7:0]  mem_byte_i;
    logic [1:0]  wr_idx_o;
    logic [7:0]  salt = 8'h5C;

    int vectors = 0;
    int fails   = 0;

    always #5 clk = ~clk;

    function automatic logic [7:0] mem_fn(input logic [31:0] a, input logic [7:0] s);
        return 8'(a[7:0] * 8'd37) ^ a[15:8] ^ a[31:24] ^ s;
    endfunction

    function automatic logic [31:0] exp_word(input logic [31:0] base, input int w, input logic [7:0] s);
        logic [31:0] r;
        for (int b = 0; b < 4; b++) r[8*b +: 8] = mem_fn(base + 32'(4*w + b), s);
        return r;
    endfunction

    assign mem_byte_i = mem_fn(mem_addr_o, salt);

    refill_engine dut (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .blk_addr_i  (blk_addr_i),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .cyc_cnt_o   (cyc_cnt_o),
        .bus_phase_o (bus_phase_o),
        .mem_rd_o    (mem_rd_o),
        .mem_addr_o  (mem_addr_o),
        .mem_byte_i  (mem_byte_i),
        .wr_en_o     (wr_en_o),
        .wr_idx_o    (wr_idx_o),
        .wr_data_o   (wr_data_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Runs one refill; kick is the counter value at which a stray start is
    // presented (negative for none).
    task automatic run_refill(input logic [31:0] addr, input int kick);
        logic [31:0] base;
        base = {addr[31:4], 4'h0};
        @(negedge clk);
        blk_addr_i = addr;
        start_i    = 1'b1;
        @(negedge clk);
        start_i    = 1'b0;
        blk_addr_i = $urandom();
        for (int n = 0; n <= 38; n++) begin
            logic exp_busy, exp_rd, exp_wr;
            exp_busy = (n <= 36);
            exp_rd   = (n >= 5) && (n <= 35) && (n % 2 == 1);
            exp_wr   = (n == 12) || (n == 20) || (n == 28) || (n == 36);
            check("R2 busy", 64'(busy_o), 64'(exp_busy));
            check("R2 count", 64'(cyc_cnt_o), 64'(n <= 36 ? n : 36));
            check("R3/R4 read strobe", 64'(mem_rd_o), 64'(exp_rd));
            check("R9 bus phase", 64'(bus_phase_o), 64'(exp_busy && (n % 2 == 1)));
            check("R7 done", 64'(done_o), 64'(n == 36));
            check("R6 write strobe", 64'(wr_en_o), 64'(exp_wr));
            if (exp_rd)
                check("R5 address", 64'(mem_addr_o), 64'(base + 32'((n - 5) / 2)));
            if (exp_wr) begin
                check("R6 index", 64'(wr_idx_o), 64'((n - 12) / 8));
                check("R6 data", 64'(wr_data_o), 64'(exp_word(base, (n - 12) / 8, salt)));
            end
            if (n > 36)
                check("R10 idle no write", 64'(wr_en_o), 64'(0));
            // R8: stray start while busy
            start_i = (n == kick);
            @(negedge clk);
            start_i = 1'b0;
        end
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 busy", 64'(busy_o), 64'(0));
        check("R1 done", 64'(done_o), 64'(0));
        check("R1 read", 64'(mem_rd_o), 64'(0));
        check("R1 write", 64'(wr_en_o), 64'(0));
        check("R1 count", 64'(cyc_cnt_o), 64'(0));
        rst = 1'b0;
        // R10: no start, no activity
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check("R10 idle read", 64'(mem_rd_o), 64'(0));
            check("R10 idle busy", 64'(busy_o), 64'(0));
        end
        run_refill(32'h0000_0000, -1);
        run_refill(32'hFFFF_FFF7, 36);   // done-cycle start ignored
        run_refill(32'h1234_567F, 0);    // start right after accept
        run_refill(32'h8000_0009, 5);    // start on first read
        for (int t = 0; t < 8; t++) begin
            salt = 8'($urandom());
            run_refill($urandom(), ($urandom_range(0, 3) == 0) ? -1 : int'($urandom_range(0, 36)));
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule